// File: doc/BRIEF.md
# Cascaded FIFO Token Ring

This block joins several identical small FIFO slots into one deeper FIFO that shares a single write port and a single read port. The slots form a ring. Every slot has a write-expansion input and output and a read-expansion input and output, and each output drives the matching input of the next slot. A write token and a separate read token travel around this ring. Only the slot that holds the write token stores incoming words. Only the slot that holds the read token supplies outgoing words. Words therefore leave the chain in the order in which they arrived, across slot boundaries.

A slot passes the write token on the cycle of the write that fills it. It pulses its write-expansion output for that one cycle and is then sealed. A sealed slot accepts no more writes until it has been read dry. It passes the read token on the cycle of the read that takes the last word from a sealed slot. It pulses its read-expansion output for that one cycle and unseals. A per-slot first-load input chooses the slot that holds both tokens after reset. The storage of each slot is a small register array with pointers and a fill level. The shared output bus is an AND-OR multiplexer steered by the read token, and the head word is shown on the output before it is read. The parameter N_INST must be 2 or more.

Top module: `fifo_token_ring`

## Requirements
- R1: After reset only the slot whose first-load input is low (index LEAD_SLOT, 0 by default) holds the write token and the read token. Every slot is empty, `empty` is 1 and `full` is 0.
- R2: At every clock edge after reset, exactly one bit of `wr_hold` is set and exactly one bit of `rd_hold` is set. Bit i of each vector stands for slot i.
- R3: A word is stored on a rising edge only when `wr_en` is 1 and `full` is 0, and it goes into the slot that holds the write token. A write attempted while `full` is 1 has no effect, and that word never appears on `rd_data`.
- R4: The write that raises the level of the write-token slot to DEPTH pulses that slot's write-expansion output for one cycle. From the next cycle on, `wr_hold` has the bit of the next slot in the ring set, where slot N_INST-1 is followed by slot 0.
- R5: A read that removes the last word of a sealed slot pulses that slot's read-expansion output for one cycle. From the next cycle on, `rd_hold` names the next slot in the ring.
- R6: While `empty` is 0, `rd_data` shows the oldest stored word. A read with `rd_en` high consumes that word on the rising edge. Words come out in the order they were accepted, across slot boundaries.
- R7: `full` is 1 exactly when the write-token slot is sealed, meaning it was filled and has not yet been read dry. `empty` is 1 exactly when the read-token slot holds no word.
- R8: A read attempted while `empty` is 1 has no effect on the stored data or on the tokens.
- R9: A slot that holds both tokens and is written and then read back to zero before it was ever filled keeps both tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides of the ring |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to store |
| rd_en | input | 1 | Read request; consumes the word on `rd_data` |
| rd_data | output | W | Oldest stored word, valid while `empty` is 0 |
| full | output | 1 | Chain cannot accept a write |
| empty | output | 1 | Chain has no word to supply |
| wr_hold | output | N_INST | One-hot: the slot that holds the write token |
| rd_hold | output | N_INST | One-hot: the slot that holds the read token |

## Verification
All state changes on the rising edge after the bench drives a request. `full`, `empty`, `rd_data`, `wr_hold` and `rd_hold` are decoded combinationally from registers, so each result is due one edge after its stimulus. A token handover shows up in `wr_hold` or `rd_hold` one edge after the filling write or the draining read. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, after exactly one rising edge. Its slot-level model of levels, seals and token positions advances once per step and is compared at those points.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  // index of the slot that feeds slot idx in a ring of n slots
  function automatic int ring_prev(input int idx, input int n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // pointer advance with wrap at limit
  function automatic int wrap_inc(input int v, input int limit);
    return (v >= limit - 1) ? 0 : v + 1;
  endfunction

  // a push that ends with the slot holding depth words
  function automatic bit fills_slot(input int level, input int depth,
                                    input bit push, input bit pop);
    return push && !pop && (level == depth - 1);
  endfunction

  // a pop that empties a sealed slot
  function automatic bit drains_slot(input int level, input bit sealed,
                                     input bit pop);
    return pop && sealed && (level == 1);
  endfunction

endpackage

// File: rtl/ring_slot_store.sv
module ring_slot_store
  import ring_fifo_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [LVL_W-1:0] lvl;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push) wp <= PTR_W'(wrap_inc(int'(wp), DEPTH));
      if (pop)  rp <= PTR_W'(wrap_inc(int'(rp), DEPTH));
      case ({push, pop})
        2'b10:   lvl <= lvl + LVL_W'(1);
        2'b01:   lvl <= lvl - LVL_W'(1);
        default: lvl <= lvl;
      endcase
    end
  end

  assign head  = mem[rp];
  assign level = lvl;

  // token logic must never push into a full slot
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (lvl != LVL_W'(DEPTH)));

  // token logic must never pop an empty slot
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (lvl != '0));

endmodule

// File: rtl/ring_slot_token.sv
module ring_slot_token
  import ring_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       first_load,
  input  logic                       wx_in,
  input  logic                       rx_in,
  input  logic                       wr_req,
  input  logic                       rd_req,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       push,
  output logic                       pop,
  output logic                       wx_out,
  output logic                       rx_out,
  output logic                       wr_own,
  output logic                       rd_own,
  output logic                       sealed
);
  logic wtok, rtok, seal_q;

  assign push   = wr_req && wtok && !seal_q;
  assign pop    = rd_req && rtok && (level != '0);
  assign wx_out = fills_slot(int'(level), DEPTH, push, pop);
  assign rx_out = drains_slot(int'(level), seal_q, pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok   <= !first_load;
      rtok   <= !first_load;
      seal_q <= 1'b0;
    end else begin
      wtok   <= (wtok && !wx_out) || wx_in;
      rtok   <= (rtok && !rx_out) || rx_in;
      seal_q <= (seal_q && !rx_out) || wx_out;
    end
  end

  assign wr_own = wtok;
  assign rd_own = rtok;
  assign sealed = seal_q;

  // write token is released after the filling write
  assert_wx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wx_out |=> !wr_own);

  // write-expansion pulse lasts a single cycle
  assert_wx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wx_out |=> !wx_out);

  // read token is released after the draining read
  assert_rx_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out |=> !rd_own);

  // a sealed slot takes no writes, so only reads can move its level
  assert_sealed_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && !pop) |=> $stable(level));

  // an unsealed read-token slot keeps the read token
  assert_keep_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_own && !sealed && !rx_in) |=> rd_own);

endmodule

// File: rtl/ring_read_mux.sv
module ring_read_mux #(
  parameter int W      = 18,
  parameter int N_INST = 3
) (
  input  logic [N_INST-1:0]        sel,
  input  logic [N_INST-1:0][W-1:0] heads,
  output logic [W-1:0]             dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N_INST; k++) begin
      if (sel[k]) dout = dout | heads[k];
    end
  end
endmodule

// File: rtl/fifo_token_ring.sv
module fifo_token_ring
  import ring_fifo_pkg::*;
#(
  parameter int W         = 18,
  parameter int N_INST    = 3,
  parameter int DEPTH     = 4,
  parameter int LEAD_SLOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  output logic              full,
  output logic              empty,
  output logic [N_INST-1:0] wr_hold,
  output logic [N_INST-1:0] rd_hold
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [N_INST-1:0]            wx, rx, wown, rown, seal_v, dry;
  logic [N_INST-1:0][W-1:0]     heads;
  logic [N_INST-1:0][LVL_W-1:0] levels;

  for (genvar i = 0; i < N_INST; i++) begin : g_slot
    localparam int PREV = ring_prev(i, N_INST);
    logic push_i, pop_i;

    ring_slot_token #(.DEPTH(DEPTH)) u_tok (
      .clk        (clk),
      .rst_n      (rst_n),
      .first_load (1'(i != LEAD_SLOT)),
      .wx_in      (wx[PREV]),
      .rx_in      (rx[PREV]),
      .wr_req     (wr_en),
      .rd_req     (rd_en),
      .level      (levels[i]),
      .push       (push_i),
      .pop        (pop_i),
      .wx_out     (wx[i]),
      .rx_out     (rx[i]),
      .wr_own     (wown[i]),
      .rd_own     (rown[i]),
      .sealed     (seal_v[i])
    );

    ring_slot_store #(.W(W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_i),
      .pop   (pop_i),
      .din   (wr_data),
      .head  (heads[i]),
      .level (levels[i])
    );

    assign dry[i] = (levels[i] == '0);
  end

  ring_read_mux #(.W(W), .N_INST(N_INST)) u_mux (
    .sel   (rown),
    .heads (heads),
    .dout  (rd_data)
  );

  assign full    = |(wown & seal_v);
  assign empty   = |(rown & dry);
  assign wr_hold = wown;
  assign rd_hold = rown;

  assert_wr_token_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wown) == 1);

  assert_rd_token_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rown) == 1);

  // only a draining read can clear a full chain
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);

  // only a write can clear an empty chain
  assert_empty_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en) |=> empty);

endmodule

// File: tb/fifo_token_ring_bench.sv
module fifo_token_ring_bench;
  localparam int W  = 18;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic full, empty;
  logic [N-1:0] wr_hold, rd_hold;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // slot-level model
  int ws = 0, rs = 0;
  int cnt [N];
  bit seal [N];
  logic [W-1:0] q [$];

  always #4 clk = ~clk;

  fifo_token_ring #(.W(W), .N_INST(N), .DEPTH(D), .LEAD_SLOT(0)) u_fifo_token_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .wr_hold(wr_hold), .rd_hold(rd_hold)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] one_hot(input int idx);
    logic [N-1:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic int ring_after(input int idx);
    return (idx + 1 == N) ? 0 : idx + 1;
  endfunction

  task automatic compare_outputs();
    bit ef = seal[ws];
    bit ee = (cnt[rs] == 0);
    chk(full === ef, "R7", "full", full, ef);
    chk(empty === ee, "R7", "empty", empty, ee);
    chk(wr_hold === one_hot(ws), "R4", "wr_hold", wr_hold, one_hot(ws));
    chk(rd_hold === one_hot(rs), "R5", "rd_hold", rd_hold, one_hot(rs));
    if (!ee && q.size() > 0)
      chk(rd_data === q[0], "R6", "rd_data", rd_data, q[0]);
  endtask

  // one cycle: check, drive at the falling edge, advance the model, wait one rising edge
  task automatic step(input bit we, input bit re, input logic [W-1:0] d);
    bit ef, ee, wgo, rgo, fill, drain;
    compare_outputs();
    ef = seal[ws];
    ee = (cnt[rs] == 0);
    wr_en = we; rd_en = re; wr_data = d;
    wgo = we && !ef;
    rgo = re && !ee;
    fill  = wgo && (cnt[ws] == D - 1) && !(rgo && rs == ws);
    drain = rgo && seal[rs] && (cnt[rs] == 1);
    if (rgo) begin void'(q.pop_front()); cnt[rs]--; end
    if (wgo) begin q.push_back(d); cnt[ws]++; end
    if (drain) begin seal[rs] = 0; rs = ring_after(rs); end
    if (fill)  begin seal[ws] = 1; ws = ring_after(ws); end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(WATCHDOG * 8);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h1d7a5));
    for (int i = 0; i < N; i++) begin cnt[i] = 0; seal[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(wr_hold === one_hot(0), "R1", "wr_hold after reset", wr_hold, one_hot(0));
    chk(rd_hold === one_hot(0), "R1", "rd_hold after reset", rd_hold, one_hot(0));
    chk(empty === 1'b1, "R1", "empty after reset", empty, 1);
    chk(full === 1'b0, "R1", "full after reset", full, 0);

    // R8: reads on an empty chain change nothing
    step(0, 1, '0);
    step(0, 1, '0);
    chk(empty === 1'b1 && rd_hold === one_hot(0), "R8", "empty read ignored",
        {empty, rd_hold}, {1'b1, one_hot(0)});

    // R9: partial fill then drain in the lead slot keeps both tokens
    step(1, 0, 18'h00a01);
    step(1, 0, 18'h00a02);
    step(0, 1, '0);
    step(0, 1, '0);
    chk(rd_hold === one_hot(0) && wr_hold === one_hot(0), "R9", "tokens kept",
        {wr_hold, rd_hold}, {one_hot(0), one_hot(0)});

    // R4/R6: write across a slot boundary, then read back in order
    for (int i = 0; i < 6; i++) step(1, 0, 18'h01000 + 18'(i));
    chk(wr_hold === one_hot(1), "R4", "write token moved", wr_hold, one_hot(1));
    for (int i = 0; i < 6; i++) step(0, 1, '0);
    chk(rd_hold === one_hot(1), "R5", "read token moved", rd_hold, one_hot(1));

    // R3: overfill; ignored writes must never appear on the output
    for (int i = 0; i < 3 * N * D; i++) step(1, 0, 18'h20000 + 18'(i));
    chk(full === 1'b1, "R3", "chain full", full, 1);
    for (int i = 0; i < 3 * N * D; i++) step(0, 1, '0);
    chk(empty === 1'b1, "R8", "drained", empty, 1);

    // mixed random traffic with bursts
    for (int i = 0; i < 6000; i++) begin
      int phase = (i / 400) % 3;
      int wp = (phase == 0) ? 80 : (phase == 1) ? 20 : 50;
      int rp = (phase == 0) ? 20 : (phase == 1) ? 80 : 50;
      v = W'($urandom);
      step(($urandom % 100) < wp, ($urandom % 100) < rp, v);
    end
    for (int i = 0; i < 2 * N * D; i++) step(0, 1, '0);
    compare_outputs();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule